// File: doc/BRIEF.md
# Keyboard controller command decoder

This block is the host-side command and data port logic of a PC-style keyboard and mouse controller. The host bus writes bytes to a command port (`cmd_wr`) and a data port (`data_wr`), and reads an 8-bit status register that the block presents directly on `status_q`. Commands are single bytes. Some of them act at once: they change the mode byte, drive the address-gate line, raise a system-reset pulse, or produce a reply byte. Others arm a pending operation, and the next data-port write supplies its operand.

Reply bytes and host-supplied buffer bytes leave the block as a one-cycle push towards the output-buffer arbiter. The push carries a flag that names the keyboard or mouse channel. Data bytes meant for the attached devices leave as one-cycle transmit strobes. The serial device protocol is handled elsewhere. Every effect of a write shows at the outputs in the clock cycle after the write strobe.

Top module: `kbc_cmd_port`

## Requirements
- R1: After reset the mode byte is 0x03, status is 0x18, the output port is 0xCF, `gate_line` is 1, `xlate_en` is 0, no strobe or pulse is active and no command is pending.
- R2: Status bit 3 is 1 in the cycle after a command-port write and 0 in the cycle after a data-port write that is accepted; status bit 2 becomes 1 after command 0xAA and then stays set.
- R3: Command 0xA7 sets mode bit 5, 0xA8 clears it, 0xAD sets mode bit 4 and 0xAE clears it.
- R4: Reply commands push one byte on the keyboard channel (`ctrl_aux`=0) in the cycle after the write: 0x20 pushes the current mode byte, 0xAA pushes 0x55, 0xA9 and 0xAB push 0x00, 0xC0 pushes 0x80 and 0xD0 pushes the current output-port value.
- R5: A command byte whose upper nibble is 0xF gives a one-cycle `sys_rst_req` pulse when bit 0 is 0, and has no effect other than status bit 3 when bit 0 is 1.
- R6: Command 0xDF sets output-port bit 1 and drives `gate_line` high. Command 0xDD clears that bit and drives `gate_line` low.
- R7: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending operation that the next accepted data write consumes. Any accepted data write leaves nothing pending. Other commands leave the pending operation unchanged.
- R8: A data write with nothing pending pulses `kbd_tx_stb` with the byte on `tx_byte` and clears mode bit 4.
- R9: A data write after 0xD4 pulses `mouse_tx_stb` with the byte on `tx_byte` and clears mode bit 5.
- R10: A data write after 0x60 replaces the whole mode byte, and `xlate_en` follows mode bit 6.
- R11: A data write after 0xD1 loads all 8 output-port bits, `gate_line` follows bit 1, and a value with bit 0 equal to 0 gives a one-cycle `sys_rst_req` pulse.
- R12: A data write after 0xD2 pushes the byte on the keyboard channel, and after 0xD3 pushes it on the mouse channel (`ctrl_aux`=1).
- R13: A command byte not named in R3 to R7 changes only status bit 3.
- R14: When `cmd_wr` and `data_wr` are both high in the same cycle, the command is executed and the data byte is dropped: no transmit strobe and no operand consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| wr_byte | input | 8 | Byte written by the host |
| status_q | output | 8 | Status register, read by the host |
| mode_q | output | 8 | Current mode byte |
| outport_q | output | 8 | Current output-port value |
| ctrl_push | output | 1 | One-cycle push of a controller byte to the arbiter |
| ctrl_aux | output | 1 | Channel of the push: 0 keyboard, 1 mouse |
| ctrl_byte | output | 8 | Byte pushed to the arbiter |
| kbd_tx_stb | output | 1 | One-cycle strobe: send `tx_byte` to the keyboard |
| mouse_tx_stb | output | 1 | One-cycle strobe: send `tx_byte` to the mouse |
| tx_byte | output | 8 | Byte for the device transmitter |
| xlate_en | output | 1 | Scan-code translation enable (mode bit 6) |
| gate_line | output | 1 | Address-gate line (output-port bit 1) |
| sys_rst_req | output | 1 | One-cycle system-reset request |

## Verification
Each iteration of the main sweep restores the reset state and then writes one of the 256 command byte values, followed by a data-port byte that depends on that command. The comparison after the command separates the immediate-action, reply, ignored and pulse-family codes from one another. The comparison after the data byte shows whether the command armed an operand capture, and which capture it armed. Further sweeps pass all 256 operand values through the mode-load path and the output-port-load path, so every bit position of `xlate_en`, `gate_line` and the reset pulse is covered. Directed sequences cover an armed operation surviving an unrelated command, and a command and a data write arriving in the same cycle.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

   // Operation selected by a command byte
   typedef enum logic [3:0] {
      OP_NONE,
      OP_QMODE,
      OP_MDIS,
      OP_MEN,
      OP_KDIS,
      OP_KEN,
      OP_STEST,
      OP_QZERO,
      OP_QIN,
      OP_QOUTP,
      OP_GATE_ON,
      OP_GATE_OFF,
      OP_SYSRST
   } op_e;

   // Operation waiting for a data-port operand
   typedef enum logic [2:0] {
      PEND_NONE,
      PEND_MODE,
      PEND_OUTP,
      PEND_KOBUF,
      PEND_MOBUF,
      PEND_MOUSE
   } pend_e;

   typedef struct packed {
      op_e   op;
      pend_e arm;
   } cmd_dec_t;

   // Command codes
   localparam logic [7:0] C_RD_MODE   = 8'h20;
   localparam logic [7:0] C_WR_MODE   = 8'h60;
   localparam logic [7:0] C_AUX_OFF   = 8'hA7;
   localparam logic [7:0] C_AUX_ON    = 8'hA8;
   localparam logic [7:0] C_AUX_TEST  = 8'hA9;
   localparam logic [7:0] C_SELFTEST  = 8'hAA;
   localparam logic [7:0] C_KBD_TEST  = 8'hAB;
   localparam logic [7:0] C_KBD_OFF   = 8'hAD;
   localparam logic [7:0] C_KBD_ON    = 8'hAE;
   localparam logic [7:0] C_RD_IN     = 8'hC0;
   localparam logic [7:0] C_RD_OUTP   = 8'hD0;
   localparam logic [7:0] C_WR_OUTP   = 8'hD1;
   localparam logic [7:0] C_WR_KOBUF  = 8'hD2;
   localparam logic [7:0] C_WR_MOBUF  = 8'hD3;
   localparam logic [7:0] C_WR_MOUSE  = 8'hD4;
   localparam logic [7:0] C_GATE_OFF  = 8'hDD;
   localparam logic [7:0] C_GATE_ON   = 8'hDF;

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
   import kbc_pkg::*;
(
   input  logic [7:0] cmd_byte,
   output cmd_dec_t   dec
);

   always_comb begin
      dec.op  = OP_NONE;
      dec.arm = PEND_NONE;
      if (cmd_byte[7:4] == 4'hF) begin
         // pulse family: only bit 0 matters
         dec.op = cmd_byte[0] ? OP_NONE : OP_SYSRST;
      end else begin
         unique case (cmd_byte)
            C_RD_MODE:  dec.op  = OP_QMODE;
            C_WR_MODE:  dec.arm = PEND_MODE;
            C_AUX_OFF:  dec.op  = OP_MDIS;
            C_AUX_ON:   dec.op  = OP_MEN;
            C_AUX_TEST: dec.op  = OP_QZERO;
            C_SELFTEST: dec.op  = OP_STEST;
            C_KBD_TEST: dec.op  = OP_QZERO;
            C_KBD_OFF:  dec.op  = OP_KDIS;
            C_KBD_ON:   dec.op  = OP_KEN;
            C_RD_IN:    dec.op  = OP_QIN;
            C_RD_OUTP:  dec.op  = OP_QOUTP;
            C_WR_OUTP:  dec.arm = PEND_OUTP;
            C_WR_KOBUF: dec.arm = PEND_KOBUF;
            C_WR_MOBUF: dec.arm = PEND_MOBUF;
            C_WR_MOUSE: dec.arm = PEND_MOUSE;
            C_GATE_OFF: dec.op  = OP_GATE_OFF;
            C_GATE_ON:  dec.op  = OP_GATE_ON;
            default:    dec.op  = OP_NONE;
         endcase
      end
   end

endmodule

// File: rtl/kbc_pend_track.sv
module kbc_pend_track
   import kbc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cmd_take,
   input  pend_e arm,
   input  logic  data_take,
   output pend_e pend
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= PEND_NONE;
      end else if (cmd_take) begin
         if (arm != PEND_NONE) pend <= arm;
      end else if (data_take) begin
         pend <= PEND_NONE;
      end
   end

endmodule

// File: rtl/kbc_ctl_regs.sv
module kbc_ctl_regs
   import kbc_pkg::*;
#(
   parameter int         W          = 8,
   parameter logic [W-1:0] MODE_RST = 8'h03,
   parameter logic [W-1:0] STAT_RST = 8'h18,
   parameter logic [W-1:0] OUTP_RST = 8'hCF,
   parameter logic [W-1:0] STEST_ACK = 8'h55,
   parameter logic [W-1:0] IFTEST_ACK = 8'h00,
   parameter logic [W-1:0] INPORT_VAL = 8'h80,
   parameter int         KDIS_BIT   = 4,
   parameter int         MDIS_BIT   = 5,
   parameter int         GATE_BIT   = 1,
   parameter int         RUN_BIT    = 0,
   parameter int         STEST_BIT  = 2,
   parameter int         LCMD_BIT   = 3
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmd_take,
   input  cmd_dec_t     dec,
   input  logic         data_take,
   input  pend_e        pend,
   input  logic [W-1:0] wbyte,
   output logic [W-1:0] mode,
   output logic [W-1:0] status,
   output logic [W-1:0] outp,
   output logic         push,
   output logic         push_aux,
   output logic [W-1:0] push_byte,
   output logic         ktx,
   output logic         mtx,
   output logic [W-1:0] tx_byte,
   output logic         rst_req
);

   // Status register: one flop per bit, behaviour chosen per position
   for (genvar i = 0; i < W; i++) begin : g_stat
      if (i == LCMD_BIT) begin : g_lcmd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         status[i] <= STAT_RST[i];
            else if (cmd_take)  status[i] <= 1'b1;
            else if (data_take) status[i] <= 1'b0;
         end
      end else if (i == STEST_BIT) begin : g_stest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status[i] <= STAT_RST[i];
            else if (cmd_take && dec.op == OP_STEST) status[i] <= 1'b1;
         end
      end else begin : g_const
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status[i] <= STAT_RST[i];
         end
      end
   end

   // Mode byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_RST;
      end else if (cmd_take) begin
         case (dec.op)
            OP_MDIS: mode[MDIS_BIT] <= 1'b1;
            OP_MEN:  mode[MDIS_BIT] <= 1'b0;
            OP_KDIS: mode[KDIS_BIT] <= 1'b1;
            OP_KEN:  mode[KDIS_BIT] <= 1'b0;
            default: ;
         endcase
      end else if (data_take) begin
         case (pend)
            PEND_NONE:  mode[KDIS_BIT] <= 1'b0;
            PEND_MOUSE: mode[MDIS_BIT] <= 1'b0;
            PEND_MODE:  mode <= wbyte;
            default: ;
         endcase
      end
   end

   // Output port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outp <= OUTP_RST;
      end else if (cmd_take) begin
         if (dec.op == OP_GATE_ON)  outp[GATE_BIT] <= 1'b1;
         if (dec.op == OP_GATE_OFF) outp[GATE_BIT] <= 1'b0;
      end else if (data_take && pend == PEND_OUTP) begin
         outp <= wbyte;
      end
   end

   // One-cycle strobes towards arbiter, transmitters and system reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         push      <= 1'b0;
         push_aux  <= 1'b0;
         push_byte <= '0;
         ktx       <= 1'b0;
         mtx       <= 1'b0;
         tx_byte   <= '0;
         rst_req   <= 1'b0;
      end else begin
         push    <= 1'b0;
         ktx     <= 1'b0;
         mtx     <= 1'b0;
         rst_req <= 1'b0;
         if (cmd_take) begin
            push_aux <= 1'b0;
            case (dec.op)
               OP_QMODE: begin push <= 1'b1; push_byte <= mode;       end
               OP_STEST: begin push <= 1'b1; push_byte <= STEST_ACK;  end
               OP_QZERO: begin push <= 1'b1; push_byte <= IFTEST_ACK; end
               OP_QIN:   begin push <= 1'b1; push_byte <= INPORT_VAL; end
               OP_QOUTP: begin push <= 1'b1; push_byte <= outp;       end
               OP_SYSRST: rst_req <= 1'b1;
               default: ;
            endcase
         end else if (data_take) begin
            tx_byte <= wbyte;
            case (pend)
               PEND_NONE:  ktx <= 1'b1;
               PEND_MOUSE: mtx <= 1'b1;
               PEND_KOBUF: begin push <= 1'b1; push_aux <= 1'b0; push_byte <= wbyte; end
               PEND_MOBUF: begin push <= 1'b1; push_aux <= 1'b1; push_byte <= wbyte; end
               PEND_OUTP:  rst_req <= ~wbyte[RUN_BIT];
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/kbc_cmd_port.sv
module kbc_cmd_port
   import kbc_pkg::*;
#(
   parameter int   W          = 8,
   parameter logic [7:0] MODE_RST = 8'h03,
   parameter logic [7:0] STAT_RST = 8'h18,
   parameter logic [7:0] OUTP_RST = 8'hCF,
   parameter int   KDIS_BIT   = 4,
   parameter int   MDIS_BIT   = 5,
   parameter int   XLATE_BIT  = 6,
   parameter int   GATE_BIT   = 1,
   parameter int   RUN_BIT    = 0,
   parameter int   STEST_BIT  = 2,
   parameter int   LCMD_BIT   = 3
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic       data_wr,
   input  logic [7:0] wr_byte,
   output logic [7:0] status_q,
   output logic [7:0] mode_q,
   output logic [7:0] outport_q,
   output logic       ctrl_push,
   output logic       ctrl_aux,
   output logic [7:0] ctrl_byte,
   output logic       kbd_tx_stb,
   output logic       mouse_tx_stb,
   output logic [7:0] tx_byte,
   output logic       xlate_en,
   output logic       gate_line,
   output logic       sys_rst_req
);

   localparam int MAXB = W - 1;

   if (W != 8) begin : g_bad_width
      $error("kbc_cmd_port: byte width must be 8");
   end
   if (KDIS_BIT > MAXB || MDIS_BIT > MAXB || XLATE_BIT > MAXB ||
       GATE_BIT > MAXB || RUN_BIT > MAXB || STEST_BIT > MAXB ||
       LCMD_BIT > MAXB) begin : g_bad_bit
      $error("kbc_cmd_port: bit position outside the byte");
   end
   if (KDIS_BIT == MDIS_BIT || STEST_BIT == LCMD_BIT) begin : g_bad_alias
      $error("kbc_cmd_port: flag bit positions must differ");
   end

   logic     cmd_take;
   logic     data_take;
   cmd_dec_t dec;
   pend_e    pend;

   // A command write wins over a data write in the same cycle
   assign cmd_take  = cmd_wr;
   assign data_take = data_wr & ~cmd_wr;

   kbc_cmd_decode u_dec (
      .cmd_byte (wr_byte),
      .dec      (dec)
   );

   kbc_pend_track u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_take  (cmd_take),
      .arm       (dec.arm),
      .data_take (data_take),
      .pend      (pend)
   );

   kbc_ctl_regs #(
      .W         (W),
      .MODE_RST  (MODE_RST),
      .STAT_RST  (STAT_RST),
      .OUTP_RST  (OUTP_RST),
      .KDIS_BIT  (KDIS_BIT),
      .MDIS_BIT  (MDIS_BIT),
      .GATE_BIT  (GATE_BIT),
      .RUN_BIT   (RUN_BIT),
      .STEST_BIT (STEST_BIT),
      .LCMD_BIT  (LCMD_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_take  (cmd_take),
      .dec       (dec),
      .data_take (data_take),
      .pend      (pend),
      .wbyte     (wr_byte),
      .mode      (mode_q),
      .status    (status_q),
      .outp      (outport_q),
      .push      (ctrl_push),
      .push_aux  (ctrl_aux),
      .push_byte (ctrl_byte),
      .ktx       (kbd_tx_stb),
      .mtx       (mouse_tx_stb),
      .tx_byte   (tx_byte),
      .rst_req   (sys_rst_req)
   );

   assign xlate_en  = mode_q[XLATE_BIT];
   assign gate_line = outport_q[GATE_BIT];

endmodule

// File: rtl/kbc_cmd_port_chk.sv
module kbc_cmd_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wr,
   input logic       data_wr,
   input logic [7:0] wr_byte,
   input logic [7:0] status_q,
   input logic [7:0] mode_q,
   input logic       ctrl_push,
   input logic       ctrl_aux,
   input logic [7:0] ctrl_byte,
   input logic       kbd_tx_stb,
   input logic       mouse_tx_stb,
   input logic       gate_line,
   input logic       sys_rst_req
);

   assert_cmd_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> status_q[3]);

   assert_data_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !cmd_wr) |=> !status_q[3]);

   assert_kbd_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_byte == 8'hAD) |=> mode_q[4]);

   assert_kbd_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_byte == 8'hAE) |=> !mode_q[4]);

   assert_read_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_byte == 8'h20) |=>
         (ctrl_push && !ctrl_aux && ctrl_byte == $past(mode_q)));

   assert_pulse_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_byte[7:4] == 4'hF && !wr_byte[0]) |=> sys_rst_req);

   assert_pulse_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_byte[7:4] == 4'hF && wr_byte[0]) |=> !sys_rst_req);

   assert_gate_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_byte == 8'hDF) |=> gate_line);

   assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_byte == 8'hDD) |=> !gate_line);

   assert_ktx_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      kbd_tx_stb |-> $past(data_wr && !cmd_wr));

   assert_mtx_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mouse_tx_stb |-> $past(data_wr && !cmd_wr));

   assert_collide_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && data_wr) |=> (!kbd_tx_stb && !mouse_tx_stb));

endmodule

bind kbc_cmd_port kbc_cmd_port_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_wr       (cmd_wr),
   .data_wr      (data_wr),
   .wr_byte      (wr_byte),
   .status_q     (status_q),
   .mode_q       (mode_q),
   .ctrl_push    (ctrl_push),
   .ctrl_aux     (ctrl_aux),
   .ctrl_byte    (ctrl_byte),
   .kbd_tx_stb   (kbd_tx_stb),
   .mouse_tx_stb (mouse_tx_stb),
   .gate_line    (gate_line),
   .sys_rst_req  (sys_rst_req)
);

// File: tb/kbc_cmd_port_bench.sv
module kbc_cmd_port_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic       data_wr = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic [7:0] status_q, mode_q, outport_q, ctrl_byte, tx_byte;
   logic       ctrl_push, ctrl_aux, kbd_tx_stb, mouse_tx_stb;
   logic       xlate_en, gate_line, sys_rst_req;

   always #2.5 clk = ~clk;   // 200 MHz

   kbc_cmd_port u_kbc_cmd_port (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_wr       (cmd_wr),
      .data_wr      (data_wr),
      .wr_byte      (wr_byte),
      .status_q     (status_q),
      .mode_q       (mode_q),
      .outport_q    (outport_q),
      .ctrl_push    (ctrl_push),
      .ctrl_aux     (ctrl_aux),
      .ctrl_byte    (ctrl_byte),
      .kbd_tx_stb   (kbd_tx_stb),
      .mouse_tx_stb (mouse_tx_stb),
      .tx_byte      (tx_byte),
      .xlate_en     (xlate_en),
      .gate_line    (gate_line),
      .sys_rst_req  (sys_rst_req)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Reference state built from the requirements
   logic [7:0] m_mode, m_stat, m_outp;
   int         m_pend;   // 0 none, 1 mode, 2 outport, 3 kbd buf, 4 mouse buf, 5 mouse
   logic       e_push, e_aux, e_ktx, e_mtx, e_rst;
   logic [7:0] e_pbyte, e_tx;

   task automatic chk(input string r, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%02h expected 0x%02h", r, what, act, exp);
      end
   endtask

   task automatic clr_exp();
      e_push = 0; e_aux = 0; e_ktx = 0; e_mtx = 0; e_rst = 0;
      e_pbyte = 8'h00; e_tx = 8'h00;
   endtask

   task automatic model_reset();
      m_mode = 8'h03; m_stat = 8'h18; m_outp = 8'hCF; m_pend = 0;
      clr_exp();
   endtask

   task automatic model_cmd(input logic [7:0] b);
      clr_exp();
      m_stat[3] = 1'b1;
      if (b[7:4] == 4'hF) begin
         e_rst = ~b[0];
      end else begin
         case (b)
            8'h20: begin e_push = 1; e_pbyte = m_mode; end
            8'h60: m_pend = 1;
            8'hD1: m_pend = 2;
            8'hD2: m_pend = 3;
            8'hD3: m_pend = 4;
            8'hD4: m_pend = 5;
            8'hA7: m_mode[5] = 1'b1;
            8'hA8: m_mode[5] = 1'b0;
            8'hAD: m_mode[4] = 1'b1;
            8'hAE: m_mode[4] = 1'b0;
            8'hAA: begin m_stat[2] = 1'b1; e_push = 1; e_pbyte = 8'h55; end
            8'hA9, 8'hAB: begin e_push = 1; e_pbyte = 8'h00; end
            8'hC0: begin e_push = 1; e_pbyte = 8'h80; end
            8'hD0: begin e_push = 1; e_pbyte = m_outp; end
            8'hDF: m_outp[1] = 1'b1;
            8'hDD: m_outp[1] = 1'b0;
            default: ;
         endcase
      end
   endtask

   task automatic model_data(input logic [7:0] b);
      clr_exp();
      m_stat[3] = 1'b0;
      case (m_pend)
         0: begin e_ktx = 1; e_tx = b; m_mode[4] = 1'b0; end
         5: begin e_mtx = 1; e_tx = b; m_mode[5] = 1'b0; end
         1: m_mode = b;
         2: begin m_outp = b; e_rst = ~b[0]; end
         3: begin e_push = 1; e_aux = 0; e_pbyte = b; end
         4: begin e_push = 1; e_aux = 1; e_pbyte = b; end
         default: ;
      endcase
      m_pend = 0;
   endtask

   function automatic string req_of(input logic [7:0] c);
      if (c[7:4] == 4'hF) return "R5";
      case (c)
         8'hA7, 8'hA8, 8'hAD, 8'hAE: return "R3";
         8'h20, 8'hAA, 8'hA9, 8'hAB, 8'hC0, 8'hD0: return "R4";
         8'hDD, 8'hDF: return "R6";
         8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: return "R7";
         default: return "R13";
      endcase
   endfunction

   task automatic check_all(input string r);
      chk(r, "mode", mode_q, m_mode);
      chk(r, "status", status_q, m_stat);
      chk(r, "outport", outport_q, m_outp);
      chk(r, "gate_line", {7'd0, gate_line}, {7'd0, m_outp[1]});
      chk(r, "xlate_en", {7'd0, xlate_en}, {7'd0, m_mode[6]});
      chk(r, "ctrl_push", {7'd0, ctrl_push}, {7'd0, e_push});
      if (e_push) begin
         chk(r, "ctrl_aux", {7'd0, ctrl_aux}, {7'd0, e_aux});
         chk(r, "ctrl_byte", ctrl_byte, e_pbyte);
      end
      chk(r, "sys_rst_req", {7'd0, sys_rst_req}, {7'd0, e_rst});
      chk(r, "kbd_tx_stb", {7'd0, kbd_tx_stb}, {7'd0, e_ktx});
      chk(r, "mouse_tx_stb", {7'd0, mouse_tx_stb}, {7'd0, e_mtx});
      if (e_ktx || e_mtx) chk(r, "tx_byte", tx_byte, e_tx);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd_wr = 0; data_wr = 0;
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   // Drive on a falling edge, let one rising edge pass, sample at the next falling edge
   task automatic wr_cmd(input logic [7:0] b);
      cmd_wr = 1; wr_byte = b;
      model_cmd(b);
      @(negedge clk);
      cmd_wr = 0;
   endtask

   task automatic wr_data(input logic [7:0] b);
      data_wr = 1; wr_byte = b;
      model_data(b);
      @(negedge clk);
      data_wr = 0;
   endtask

   initial begin
      do_reset();
      @(negedge clk);
      check_all("R1");

      // Sweep of every command byte, each followed by a data byte
      for (int c = 0; c < 256; c++) begin
         logic [7:0] cb, db;
         string      rd;
         cb = 8'(c);
         db = 8'((c * 37 + 11) & 255);
         do_reset();
         wr_cmd(cb);
         check_all(req_of(cb));
         case (m_pend)
            0: rd = "R8";
            1: rd = "R10";
            2: rd = "R11";
            3, 4: rd = "R12";
            default: rd = "R9";
         endcase
         wr_data(db);
         check_all(rd);
      end

      // Mode load with every operand value
      do_reset();
      for (int v = 0; v < 256; v++) begin
         wr_cmd(8'h60);
         check_all("R7");
         wr_data(8'(v));
         check_all("R10");
      end

      // Output-port load with every operand value
      do_reset();
      for (int v = 0; v < 256; v++) begin
         wr_cmd(8'hD1);
         wr_data(8'(v));
         check_all("R11");
         wr_cmd(8'hD0);
         check_all("R4");
      end

      // Armed operation survives unrelated commands
      do_reset();
      wr_cmd(8'hD4);
      wr_cmd(8'hAD);
      wr_cmd(8'h42);
      check_all("R7");
      wr_data(8'h77);
      check_all("R9");
      wr_data(8'h78);
      check_all("R8");

      // Self-test flag stays set
      do_reset();
      wr_cmd(8'hAA);
      wr_data(8'h01);
      wr_cmd(8'hA8);
      check_all("R2");

      // Command and data in the same cycle
      do_reset();
      wr_cmd(8'hD2);
      cmd_wr = 1; data_wr = 1; wr_byte = 8'hAD;
      model_cmd(8'hAD);
      @(negedge clk);
      cmd_wr = 0; data_wr = 0;
      check_all("R14");
      wr_data(8'h9C);
      check_all("R14");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule